// File: doc/BRIEF.md
# Hybrid Register and Memory Delay Line

This block presents a WIDTH-bit bus at its output exactly CYCLES enabled clock cycles after the bus was sampled at its input. The delay is built from two kinds of segment joined in series. The first is a shift chain of flip-flops. The second is a ring buffer held in an inferred single-clock memory. Parameters set how many of the CYCLES go to each kind, and which kind comes first. The bus can also be cut at bit SPLIT_AT into a low column and a high column. Each column gets its own split between register and memory. All of these choices behave the same at the ports, so an integrator can trade flip-flops against memory words without changing the surrounding logic.

The data path has no valid/ready handshake and no back-pressure. The single `enable` input is the advance strobe. On a clock edge where `enable` is high, every segment takes one step and `data_in` is captured. On an edge where `enable` is low, every stage, pointer and the output all hold. A producer that must stall simply drops `enable`, and the consumer sees the same word until the line advances again. Words that leave the output while `enable` is low are not lost, because nothing moves.

Top module: `hybrid_delay`

## Requirements
- R1: After at least CYCLES enabled edges since reset, `data_out` equals the `data_in` value captured CYCLES enabled edges earlier, on every bit. This includes a 40-bit, 513-cycle line built as 1 register stage plus a 512-word memory segment.
- R2: On an edge where `enable` is low, no stage or pointer changes, and `data_out` keeps its value.
- R3: A line whose whole delay sits in the register segment (no memory segment) meets R1.
- R4: A line whose whole delay sits in the memory segment (no register segment) meets R1. This includes a 1-cycle memory segment.
- R5: A 64-cycle line split 32 register + 32 memory gives the same output stream whether the register segment comes first (ORDER = 0) or the memory segment comes first (ORDER = 1).
- R6: With SPLIT_AT = M (0 < M < WIDTH), bits [M-1:0] and bits [WIDTH-1:M] are delayed by separate columns with different register/memory splits, and the output still meets R1 on every bit.
- R7: CYCLES = 0 makes `data_out` a combinational copy of `data_in`.
- R8: The memory write pointer stays below the segment depth and wraps to 0 after depth-1. A 2-word memory segment still gives an exact 2-cycle delay.
- R9: While `rst` is high, all register stages and the memory read register clear to zero, so `data_out` reads zero. Memory words are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Advance strobe; low freezes the whole line |
| data_in | input | WIDTH | Word entering the line |
| data_out | output | WIDTH | Word delayed by CYCLES enabled edges |

## Verification
The hardest situation to reach from the ports is the memory pointer wrapping while `enable` drops at irregular points. If the read-ahead address and the write address fall out of step, the fault only shows after a full trip around the ring. The stimulus table therefore mixes enabled and stalled cycles in an uneven 16-step pattern. It runs long enough for the 512-word ring to wrap, and for the 32-word and 2-word rings to wrap many times. Every configuration sees the same input stream and is compared with one history-based model. A mid-run reset followed by a refill checks that the pointers restart cleanly.

// File: rtl/hd_pkg.sv
package hd_pkg;

  // Order of the two segments inside one column.
  typedef enum logic {
    ORDER_REG_FIRST = 1'b0,
    ORDER_RAM_FIRST = 1'b1
  } seg_order_e;

  // Register cycles actually used, never more than the total.
  function automatic int clamp_reg(input int total, input int want);
    return (want > total) ? total : ((want < 0) ? 0 : want);
  endfunction

endpackage

// File: rtl/hd_reg_chain.sv
module hd_reg_chain #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) stg[i] <= '0;
    end else if (en) begin
      stg[0] <= d;
      for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[N-1];

  // R2: a stalled edge leaves the chain output untouched
  p_chain_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

  // R9: reset clears the tail stage
  p_chain_reset_r9: assert property (@(posedge clk)
    rst |=> (q == '0) || !$past(rst));

endmodule

// File: rtl/hd_ram_ring.sv
module hd_ram_ring #(
  parameter int W = 8,
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (N == 1) begin : g_single
      // A one-cycle segment is just the read register.
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (en) q_r <= d;
      end
      assign q = q_r;
    end else begin : g_ring
      localparam int AW = $clog2(N);
      localparam logic [AW-1:0] LAST = AW'(N - 1);

      logic [W-1:0]  mem [N];
      logic [AW-1:0] wp;
      logic [AW-1:0] rp;
      logic [W-1:0]  q_r;

      // Read one slot ahead of the write slot: that word was written
      // N-1 enabled edges ago, and the read register adds the last cycle.
      assign rp = (wp == LAST) ? '0 : wp + 1'b1;

      always_ff @(posedge clk) begin
        if (en) mem[wp] <= d;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          wp  <= '0;
          q_r <= '0;
        end else if (en) begin
          wp  <= rp;
          q_r <= mem[rp];
        end
      end

      assign q = q_r;

      // R8: write pointer never leaves the ring
      p_ptr_range_r8: assert property (@(posedge clk) disable iff (rst)
        wp <= LAST);

      // R8: pointer wraps to zero after the last slot
      p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (en && wp == LAST) |=> (wp == '0));

      // R2: stalled edge freezes pointer and read register
      p_ring_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(wp) && $stable(q_r)));
    end
  endgenerate

endmodule

// File: rtl/hd_column.sv
module hd_column #(
  parameter int W = 8,
  parameter int REG_N = 2,
  parameter int RAM_N = 2,
  parameter hd_pkg::seg_order_e ORDER = hd_pkg::ORDER_REG_FIRST
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] seg_a_in, seg_a_out, seg_b_in, seg_b_out;

  // Segment A is whichever comes first, segment B the second.
  localparam bit REG_IS_A = (ORDER == hd_pkg::ORDER_REG_FIRST);

  assign seg_a_in = d;
  assign seg_b_in = seg_a_out;
  assign q        = seg_b_out;

  generate
    if (REG_IS_A) begin : g_reg_first
      if (REG_N > 0) begin : g_reg
        hd_reg_chain #(.W(W), .N(REG_N)) u_reg (
          .clk(clk), .rst(rst), .en(en), .d(seg_a_in), .q(seg_a_out));
      end else begin : g_reg_skip
        assign seg_a_out = seg_a_in;
      end
      if (RAM_N > 0) begin : g_ram
        hd_ram_ring #(.W(W), .N(RAM_N)) u_ram (
          .clk(clk), .rst(rst), .en(en), .d(seg_b_in), .q(seg_b_out));
      end else begin : g_ram_skip
        assign seg_b_out = seg_b_in;
      end
    end else begin : g_ram_first
      if (RAM_N > 0) begin : g_ram
        hd_ram_ring #(.W(W), .N(RAM_N)) u_ram (
          .clk(clk), .rst(rst), .en(en), .d(seg_a_in), .q(seg_a_out));
      end else begin : g_ram_skip
        assign seg_a_out = seg_a_in;
      end
      if (REG_N > 0) begin : g_reg
        hd_reg_chain #(.W(W), .N(REG_N)) u_reg (
          .clk(clk), .rst(rst), .en(en), .d(seg_b_in), .q(seg_b_out));
      end else begin : g_reg_skip
        assign seg_b_out = seg_b_in;
      end
    end
  endgenerate

endmodule

// File: rtl/hybrid_delay.sv
module hybrid_delay #(
  parameter int WIDTH      = 21,
  parameter int CYCLES     = 64,
  parameter int SPLIT_AT   = 0,
  parameter int LO_REG_CYC = 32,
  parameter int HI_REG_CYC = 32,
  parameter hd_pkg::seg_order_e ORDER = hd_pkg::ORDER_REG_FIRST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] data_out
);

  localparam int  LO_REG = hd_pkg::clamp_reg(CYCLES, LO_REG_CYC);
  localparam int  LO_RAM = CYCLES - LO_REG;
  localparam int  HI_REG = hd_pkg::clamp_reg(CYCLES, HI_REG_CYC);
  localparam int  HI_RAM = CYCLES - HI_REG;
  localparam bit  SPLIT  = (SPLIT_AT > 0) && (SPLIT_AT < WIDTH);
  localparam int  LO_W   = SPLIT ? SPLIT_AT : WIDTH;
  localparam int  HI_W   = SPLIT ? (WIDTH - SPLIT_AT) : 1;

  generate
    if (CYCLES == 0) begin : g_wire
      assign data_out = data_in;
    end else begin : g_line
      hd_column #(.W(LO_W), .REG_N(LO_REG), .RAM_N(LO_RAM), .ORDER(ORDER)) u_lo (
        .clk(clk), .rst(rst), .en(enable),
        .d(data_in[LO_W-1:0]), .q(data_out[LO_W-1:0]));

      if (SPLIT) begin : g_hi
        hd_column #(.W(HI_W), .REG_N(HI_REG), .RAM_N(HI_RAM), .ORDER(ORDER)) u_hi (
          .clk(clk), .rst(rst), .en(enable),
          .d(data_in[WIDTH-1:LO_W]), .q(data_out[WIDTH-1:LO_W]));
      end

      // R2: the whole bus holds across a stalled edge
      p_hold_out_r2: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(data_out));

      // R9: output reads zero right after a reset edge
      p_reset_out_r9: assert property (@(posedge clk)
        rst |=> (data_out == '0) || !$past(rst));
    end
  endgenerate

endmodule

// File: tb/test_hybrid_delay.sv
module test_hybrid_delay;

  localparam int HW = 40;
  localparam int HDEPTH = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [HW-1:0] din = '0;

  logic [20:0] o_main, o_ramfirst, o_reg, o_ram, o_split, o_two, o_one, o_wire;
  logic [39:0] o_long;

  int checks = 0;
  int errors = 0;
  int n = 0;
  logic [HW-1:0] hist [HDEPTH];

  always #5 clk = ~clk;

  // R5: 32 register + 32 memory, register first
  hybrid_delay #(.WIDTH(21), .CYCLES(64), .LO_REG_CYC(32)) i_hybrid_delay (
    .clk(clk), .rst(rst), .enable(en), .data_in(din[20:0]), .data_out(o_main));
  // R5: same split, memory first
  hybrid_delay #(.WIDTH(21), .CYCLES(64), .LO_REG_CYC(32),
    .ORDER(hd_pkg::ORDER_RAM_FIRST)) i_hybrid_delay_ramfirst (
    .clk(clk), .rst(rst), .enable(en), .data_in(din[20:0]), .data_out(o_ramfirst));
  // R3: registers only
  hybrid_delay #(.WIDTH(21), .CYCLES(64), .LO_REG_CYC(64)) i_hybrid_delay_reg (
    .clk(clk), .rst(rst), .enable(en), .data_in(din[20:0]), .data_out(o_reg));
  // R4: memory only
  hybrid_delay #(.WIDTH(21), .CYCLES(64), .LO_REG_CYC(0)) i_hybrid_delay_ram (
    .clk(clk), .rst(rst), .enable(en), .data_in(din[20:0]), .data_out(o_ram));
  // R6: low 20 bits mixed, top bit all memory
  hybrid_delay #(.WIDTH(21), .CYCLES(64), .SPLIT_AT(20), .LO_REG_CYC(32),
    .HI_REG_CYC(0)) i_hybrid_delay_split (
    .clk(clk), .rst(rst), .enable(en), .data_in(din[20:0]), .data_out(o_split));
  // R8: shortest ring
  hybrid_delay #(.WIDTH(21), .CYCLES(2), .LO_REG_CYC(0)) i_hybrid_delay_two (
    .clk(clk), .rst(rst), .enable(en), .data_in(din[20:0]), .data_out(o_two));
  // R4: one-cycle memory segment
  hybrid_delay #(.WIDTH(21), .CYCLES(1), .LO_REG_CYC(0)) i_hybrid_delay_one (
    .clk(clk), .rst(rst), .enable(en), .data_in(din[20:0]), .data_out(o_one));
  // R7: direct wire
  hybrid_delay #(.WIDTH(21), .CYCLES(0), .LO_REG_CYC(0)) i_hybrid_delay_wire (
    .clk(clk), .rst(rst), .enable(en), .data_in(din[20:0]), .data_out(o_wire));
  // R1: 40 bits, 513 cycles as 1 register + 512 memory words
  hybrid_delay #(.WIDTH(40), .CYCLES(513), .LO_REG_CYC(1)) i_hybrid_delay_long (
    .clk(clk), .rst(rst), .enable(en), .data_in(din), .data_out(o_long));

  // Stimulus table: bit 40 is the enable, bits 39:0 the base data word.
  localparam logic [40:0] PAT [16] = '{
    {1'b1, 40'h00_0000_0000}, {1'b1, 40'hFF_FFFF_FFFF},
    {1'b0, 40'hA5_A5A5_A5A5}, {1'b1, 40'h5A_5A5A_5A5A},
    {1'b1, 40'h01_0000_0001}, {1'b1, 40'h80_0010_0000},
    {1'b0, 40'h12_3456_789A}, {1'b0, 40'hFE_DCBA_9876},
    {1'b1, 40'h0F_0F0F_0F0F}, {1'b1, 40'hF0_F0F0_F0F0},
    {1'b1, 40'h3C_C33C_C33C}, {1'b0, 40'h00_0010_0000},
    {1'b1, 40'h7F_FFFF_FFFE}, {1'b1, 40'h55_5555_5555},
    {1'b1, 40'hAA_AAAA_AAAA}, {1'b1, 40'h80_0000_0001}
  };

  task automatic chk(input string req, input string who,
                     input logic [HW-1:0] act, input logic [HW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (enabled edges %0d)",
               req, who, act, exp, n);
    end
  endtask

  function automatic logic [HW-1:0] past_in(input int c);
    return hist[(n - c) % HDEPTH];
  endfunction

  // Compare every delayed output with the history model (at negedge).
  task automatic check_lines(input bit stalled);
    string t;
    t = stalled ? "R2" : "";
    if (n >= 64) begin
      chk(stalled ? t : "R5", "reg-first", {19'b0, o_main},     {19'b0, past_in(64)[20:0]});
      chk(stalled ? t : "R5", "ram-first", {19'b0, o_ramfirst}, {19'b0, past_in(64)[20:0]});
      chk(stalled ? t : "R3", "reg-only",  {19'b0, o_reg},      {19'b0, past_in(64)[20:0]});
      chk(stalled ? t : "R4", "ram-only",  {19'b0, o_ram},      {19'b0, past_in(64)[20:0]});
      chk(stalled ? t : "R6", "split",     {19'b0, o_split},    {19'b0, past_in(64)[20:0]});
      chk(stalled ? t : "R5", "order-match", {19'b0, o_main},   {19'b0, o_ramfirst});
    end
    if (n >= 2)   chk(stalled ? t : "R8", "ring-2",  {19'b0, o_two}, {19'b0, past_in(2)[20:0]});
    if (n >= 1)   chk(stalled ? t : "R4", "ram-1",   {19'b0, o_one}, {19'b0, past_in(1)[20:0]});
    if (n >= 513) chk(stalled ? t : "R1", "long-513", o_long, past_in(513));
  endtask

  // One cycle: check at negedge, drive, let the edge happen.
  task automatic step(input logic e, input logic [HW-1:0] v);
    @(negedge clk);
    check_lines(!e);
    en  = e;
    din = v;
    #1;
    chk("R7", "wire", {19'b0, o_wire}, {19'b0, v[20:0]});
    if (e) hist[n % HDEPTH] = v;
    @(posedge clk);
    if (e) n++;
  endtask

  task automatic check_reset_zero();
    chk("R9", "reg-first", {19'b0, o_main},     '0);
    chk("R9", "ram-first", {19'b0, o_ramfirst}, '0);
    chk("R9", "reg-only",  {19'b0, o_reg},      '0);
    chk("R9", "ram-only",  {19'b0, o_ram},      '0);
    chk("R9", "split",     {19'b0, o_split},    '0);
    chk("R9", "ring-2",    {19'b0, o_two},      '0);
    chk("R9", "ram-1",     {19'b0, o_one},      '0);
    chk("R9", "long-513",  o_long,              '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Reset state (R9)
    rst = 1'b1;
    en  = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_zero();
    rst = 1'b0;
    en  = 1'b0;
    n   = 0;

    // Table walk: uneven enable pattern, long enough to wrap every ring.
    for (int i = 0; i < 1200; i++) begin
      logic [40:0] row;
      row = PAT[i % 16];
      step(row[40], row[39:0] ^ (40'(i) * 40'h00_9E37_79B1));
    end

    // Long stall: everything must hold (R2)
    for (int i = 0; i < 20; i++) step(1'b0, 40'(i) * 40'h11_1111_1111);

    // Mid-run reset (R9), then refill with pointers restarting at zero (R8)
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset_zero();
    rst = 1'b0;
    en  = 1'b0;
    n   = 0;
    for (int i = 0; i < 700; i++) begin
      logic [40:0] row;
      row = PAT[(i * 7) % 16];
      step(row[40] | (i < 100), ~row[39:0] + 40'(i * 3));
    end

    // Alternating enable right at the end (R2, R8)
    for (int i = 0; i < 40; i++) step(i[0], 40'(i) << (i % 20));

    @(negedge clk);
    check_lines(1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule